// File: doc/BRIEF.md
# PWM Event-Trigger Prescaler

This block sits behind a PWM timebase and thins out the timing events it produces. There are three channels. Each channel receives its own one-cycle qualifying-event strobe and counts it against a 2-bit period. When the count reaches the period, the channel emits a single-cycle output pulse. Channel 0 is an interrupt request. Channels 1 and 2 are ADC start-of-conversion triggers, called A and B.

Every channel has an enable, a sticky status flag, a one-cycle clear strobe and a one-cycle force strobe. The three period fields are loaded together through a single-cycle write port. Software can read each event count and a packed flag word.

The interrupt channel will not emit while its flag is set. It parks its count at the period, so exactly one interrupt stays pending until software clears the flag. The conversion channels ignore their flags when deciding to fire.

Top module: `evt_trig_prescaler`

## Requirements
- R1: A channel with period 0 does not count events outside a write cycle and never emits a pulse. A force strobe on it is ignored.
- R2: `prd_wdata` carries the interrupt period in bits 1:0, trigger A in bits 3:2 and trigger B in bits 5:4. With period N (1 to 3) and an enabled channel whose pulse is not blocked, the Nth qualifying event produces the pulse. The readable count shows the number of events seen, and it returns to 0 in the cycle the pulse is shown.
- R3: The outputs update one clock after the inputs are sampled. A pulse is one clock wide and sets its channel's flag in the same cycle. When a clear and a new pulse coincide, the flag ends up set.
- R4: The interrupt pulse needs `int_en`=1 and a clear interrupt flag. While the flag is set, the count waits at the period. The pending interrupt is emitted one clock after the clear has taken effect.
- R5: A channel that cannot fire holds its count at the period and does not wrap. This covers an interrupt that is disabled or has its flag set, and a trigger that is disabled. A disabled trigger fires as soon as it is re-enabled.
- R6: A conversion trigger fires at its period even while its own flag is still set.
- R7: Writing a period equal to the current count fires the channel in that cycle if it is enabled (and, for the interrupt, if its flag is clear).
- R8: A qualifying event in the same cycle as a period write is counted, including a write of period 0.
- R9: Writing a period smaller than the current count restarts the counter. The count becomes 1 if an event coincides, otherwise 0. No pulse is emitted in that cycle.
- R10: A force strobe emits the pulse at once under the same gating as a counted pulse, and clears the count.
- R11: `flag_rd` places the interrupt flag at bit 0, trigger A at bit 2 and trigger B at bit 3. All other bits read 0.
- R12: An active-low synchronous reset clears periods, counts, flags and pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_evt | input | 1 | Qualifying event strobe, interrupt channel |
| soca_evt | input | 1 | Qualifying event strobe, trigger A |
| socb_evt | input | 1 | Qualifying event strobe, trigger B |
| int_en | input | 1 | Interrupt enable |
| soca_en | input | 1 | Trigger A enable |
| socb_en | input | 1 | Trigger B enable |
| int_clr | input | 1 | Clear strobe for the interrupt flag |
| soca_clr | input | 1 | Clear strobe for the trigger A flag |
| socb_clr | input | 1 | Clear strobe for the trigger B flag |
| int_frc | input | 1 | Force strobe, interrupt |
| soca_frc | input | 1 | Force strobe, trigger A |
| socb_frc | input | 1 | Force strobe, trigger B |
| prd_we | input | 1 | Period write enable |
| prd_wdata | input | 6 | Period write data, three 2-bit fields |
| int_pulse | output | 1 | Interrupt request pulse |
| soca_pulse | output | 1 | Conversion trigger A pulse |
| socb_pulse | output | 1 | Conversion trigger B pulse |
| int_cnt | output | 2 | Interrupt event count |
| soca_cnt | output | 2 | Trigger A event count |
| socb_cnt | output | 2 | Trigger B event count |
| flag_rd | output | 8 | Packed status flags |

## Verification
A vector table drives all three channels together with different periods (2, 2 and 3). A single run therefore shows the flag-gated interrupt stalling while the ungated triggers keep firing. The same table also separates a count held at the period from a count that wraps. A disabled trigger and its re-enable show that firing comes from count equals period, not from the event edge. Directed steps then cover the write-time cases: an event coinciding with a write, a write equal to the count, and a write below the count. They also cover force with period 0 against force with period 1, a clear coinciding with a set, and the packed flag positions.

// File: rtl/etp_pkg.sv
// Shared constants for the event-trigger prescaler.
// Assumes three channels in a fixed order: interrupt, trigger A, trigger B.
package etp_pkg;
    parameter int CNT_W = 2;
    localparam int NCH    = 3;
    localparam int FLAG_W = 8;
    localparam int CH_INT  = 0;
    localparam int CH_SOCA = 1;
    localparam int CH_SOCB = 2;
    localparam int FLG_POS_INT  = 0;
    localparam int FLG_POS_SOCA = 2;
    localparam int FLG_POS_SOCB = 3;
endpackage

// File: rtl/etp_chan.sv
// One prescaler channel: period register, event counter, sticky flag and
// registered one-cycle pulse. GATED=1 makes the flag block new pulses
// (interrupt behaviour); GATED=0 fires regardless of the flag.
// Assumes evt, clr and frc are one-cycle strobes.
module etp_chan #(
    parameter int CNT_W = 2,
    parameter bit GATED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             en,
    input  logic             clr,
    input  logic             frc,
    input  logic             we,
    input  logic [CNT_W-1:0] wprd,
    output logic             pulse,
    output logic             flag,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] prd_q, prd_nxt, cnt_q, cnt_nxt, cnt_inc;
    logic             flag_q, pulse_q, fire, can_fire, bad_wr, inc;

    // Next-state logic for count and pulse decision.
    always_comb begin
        prd_nxt  = we ? wprd : prd_q;
        bad_wr   = we && (wprd < cnt_q);
        can_fire = en && (prd_nxt != ZERO) && (!GATED || !flag_q);
        inc      = evt && (we || prd_nxt != ZERO) && (cnt_q != CMAX)
                   && ((prd_nxt == ZERO) || (cnt_q < prd_nxt));
        cnt_inc  = cnt_q + {{(CNT_W-1){1'b0}}, inc};
        if (bad_wr) begin
            fire    = 1'b0;
            cnt_nxt = {{(CNT_W-1){1'b0}}, evt};
        end else begin
            fire    = can_fire && ((cnt_inc == prd_nxt) || frc);
            cnt_nxt = fire ? ZERO : cnt_inc;
        end
    end

    // State registers: period, count, flag (set beats clear), pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q   <= ZERO;
            cnt_q   <= ZERO;
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prd_q   <= prd_nxt;
            cnt_q   <= cnt_nxt;
            flag_q  <= fire ? 1'b1 : (clr ? 1'b0 : flag_q);
            pulse_q <= fire;
        end
    end

    assign pulse = pulse_q;
    assign flag  = flag_q;
    assign cnt   = cnt_q;

    assert_flag_on_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q);
    assert_cnt_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (cnt_q == ZERO));
    assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_q == ZERO && !we) |=> !pulse_q);
    assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_q != ZERO) |-> (cnt_q <= prd_q));
    assert_badwr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wprd < cnt_q)) |=> !pulse_q);

    if (GATED) begin : g_gate_chk
        assert_pending_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q |=> !pulse_q);
    end
endmodule

// File: rtl/etp_flag_pack.sv
// Packs the per-channel flags into the readable flag word at fixed bit
// positions; all unused positions read zero. Purely combinational.
module etp_flag_pack
    import etp_pkg::*;
(
    input  logic [NCH-1:0]    flags,
    output logic [FLAG_W-1:0] word
);
    // Place each flag at its fixed position.
    always_comb begin
        word               = '0;
        word[FLG_POS_INT]  = flags[CH_INT];
        word[FLG_POS_SOCA] = flags[CH_SOCA];
        word[FLG_POS_SOCB] = flags[CH_SOCB];
    end
endmodule

// File: rtl/evt_trig_prescaler.sv
// Event-trigger prescaler top: one flag-gated interrupt channel and two
// ungated conversion-trigger channels sharing a period write port.
// Assumes single-cycle strobes on all evt/clr/frc/we inputs.
module evt_trig_prescaler
    import etp_pkg::*;
#(
    parameter int CW = etp_pkg::CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                int_evt,
    input  logic                soca_evt,
    input  logic                socb_evt,
    input  logic                int_en,
    input  logic                soca_en,
    input  logic                socb_en,
    input  logic                int_clr,
    input  logic                soca_clr,
    input  logic                socb_clr,
    input  logic                int_frc,
    input  logic                soca_frc,
    input  logic                socb_frc,
    input  logic                prd_we,
    input  logic [NCH*CW-1:0]   prd_wdata,
    output logic                int_pulse,
    output logic                soca_pulse,
    output logic                socb_pulse,
    output logic [CW-1:0]       int_cnt,
    output logic [CW-1:0]       soca_cnt,
    output logic [CW-1:0]       socb_cnt,
    output logic [FLAG_W-1:0]   flag_rd
);
    logic [NCH-1:0]    evt_v, en_v, clr_v, frc_v, pulse_v, flag_v;
    logic [NCH*CW-1:0] cnt_v;

    assign evt_v = {socb_evt, soca_evt, int_evt};
    assign en_v  = {socb_en,  soca_en,  int_en};
    assign clr_v = {socb_clr, soca_clr, int_clr};
    assign frc_v = {socb_frc, soca_frc, int_frc};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        etp_chan #(
            .CNT_W (CW),
            .GATED (i == CH_INT)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_v[i]),
            .en    (en_v[i]),
            .clr   (clr_v[i]),
            .frc   (frc_v[i]),
            .we    (prd_we),
            .wprd  (prd_wdata[i*CW +: CW]),
            .pulse (pulse_v[i]),
            .flag  (flag_v[i]),
            .cnt   (cnt_v[i*CW +: CW])
        );
    end

    etp_flag_pack u_pack (
        .flags (flag_v),
        .word  (flag_rd)
    );

    assign int_pulse  = pulse_v[CH_INT];
    assign soca_pulse = pulse_v[CH_SOCA];
    assign socb_pulse = pulse_v[CH_SOCB];
    assign int_cnt    = cnt_v[CH_INT*CW  +: CW];
    assign soca_cnt   = cnt_v[CH_SOCA*CW +: CW];
    assign socb_cnt   = cnt_v[CH_SOCB*CW +: CW];
endmodule

// File: tb/sim_evt_trig_prescaler.sv
`timescale 1ns/100ps
module sim_evt_trig_prescaler;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] evt, en, clr, frc;
    logic       we;
    logic [5:0] wd;
    logic       p_i, p_a, p_b;
    logic [1:0] c_i, c_a, c_b;
    logic [7:0] flags;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evt_trig_prescaler u0 (
        .clk(clk), .rst_n(rst_n),
        .int_evt(evt[0]), .soca_evt(evt[1]), .socb_evt(evt[2]),
        .int_en(en[0]), .soca_en(en[1]), .socb_en(en[2]),
        .int_clr(clr[0]), .soca_clr(clr[1]), .socb_clr(clr[2]),
        .int_frc(frc[0]), .soca_frc(frc[1]), .socb_frc(frc[2]),
        .prd_we(we), .prd_wdata(wd),
        .int_pulse(p_i), .soca_pulse(p_a), .socb_pulse(p_b),
        .int_cnt(c_i), .soca_cnt(c_a), .socb_cnt(c_b),
        .flag_rd(flags)
    );

    // evt[28:26] en[25:23] clr[22:20] frc[19:17] we[16] wd[15:10]
    // exp pulses {B,A,I}[9:7] exp flags {B,A,I}[6:4] exp int cnt[3:2] exp A cnt[1:0]
    localparam int NV = 13;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {3'b000,3'b000,3'b000,3'b000,1'b1,6'b111010,3'b000,3'b000,2'd0,2'd0},
        {3'b111,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b000,3'b000,2'd1,2'd1},
        {3'b111,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b011,3'b011,2'd0,2'd0},
        {3'b111,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b100,3'b111,2'd1,2'd1},
        {3'b111,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b010,3'b111,2'd2,2'd0},
        {3'b001,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b000,3'b111,2'd2,2'd0},
        {3'b000,3'b111,3'b001,3'b000,1'b0,6'b000000,3'b000,3'b110,2'd2,2'd0},
        {3'b000,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b001,3'b111,2'd0,2'd0},
        {3'b000,3'b111,3'b111,3'b000,1'b0,6'b000000,3'b000,3'b000,2'd0,2'd0},
        {3'b010,3'b101,3'b000,3'b000,1'b0,6'b000000,3'b000,3'b000,2'd0,2'd1},
        {3'b010,3'b101,3'b000,3'b000,1'b0,6'b000000,3'b000,3'b000,2'd0,2'd2},
        {3'b010,3'b101,3'b000,3'b000,1'b0,6'b000000,3'b000,3'b000,2'd0,2'd2},
        {3'b000,3'b111,3'b000,3'b000,1'b0,6'b000000,3'b010,3'b010,2'd0,2'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, return at the next falling edge.
    task automatic step(input logic [2:0] e, input logic [2:0] n, input logic [2:0] c,
                        input logic [2:0] f, input logic w, input logic [5:0] d);
        evt = e; en = n; clr = c; frc = f; we = w; wd = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; evt = '0; en = '0; clr = '0; frc = '0; we = 1'b0; wd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 pulses", {p_b, p_a, p_i}, 0);
        chk("R12 flags", flags, 0);
        chk("R12 counts", {c_b, c_a, c_i}, 0);

        // Table walk: R2 R4 R5 R6 R3
        for (int k = 0; k < NV; k++) begin
            logic [28:0] v;
            v = VEC[k];
            step(v[28:26], v[25:23], v[22:20], v[19:17], v[16], v[15:10]);
            chk($sformatf("R2 R4 R5 R6 vec%0d pulses", k), {p_b, p_a, p_i}, v[9:7]);
            chk($sformatf("R3 R4 vec%0d flags", k), {flags[3], flags[2], flags[0]}, v[6:4]);
            chk($sformatf("R2 R5 vec%0d int_cnt", k), c_i, v[3:2]);
            chk($sformatf("R2 R5 vec%0d soca_cnt", k), c_a, v[1:0]);
        end

        // R12 mid-run reset clears flags and counts
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R12 flags after reset", flags, 0);
        chk("R12 counts after reset", {c_b, c_a, c_i}, 0);
        rst_n = 1'b1;

        // R1 period 0: no counting, force ignored
        step(3'b111, 3'b111, 3'b000, 3'b000, 1'b0, 6'd0);
        step(3'b111, 3'b111, 3'b000, 3'b000, 1'b0, 6'd0);
        chk("R1 no count at period 0", {c_b, c_a, c_i}, 0);
        step(3'b000, 3'b111, 3'b000, 3'b111, 1'b0, 6'd0);
        chk("R1 force ignored pulses", {p_b, p_a, p_i}, 0);
        chk("R1 force ignored flags", flags, 0);

        // R8 event coinciding with write is counted
        step(3'b001, 3'b111, 3'b000, 3'b000, 1'b1, 6'b000011);
        chk("R8 int_cnt", c_i, 1);
        chk("R8 no pulse", p_i, 0);

        // R7 write period equal to count fires
        step(3'b000, 3'b111, 3'b000, 3'b000, 1'b1, 6'b000001);
        chk("R7 int pulse", p_i, 1);
        chk("R7 int_cnt cleared", c_i, 0);

        // R9 write below count restarts without pulse
        step(3'b000, 3'b111, 3'b000, 3'b000, 1'b1, 6'b000011);
        step(3'b001, 3'b111, 3'b000, 3'b000, 1'b0, 6'd0);
        step(3'b001, 3'b111, 3'b000, 3'b000, 1'b0, 6'd0);
        chk("R9 count before rewrite", c_i, 2);
        step(3'b000, 3'b111, 3'b000, 3'b000, 1'b1, 6'b000001);
        chk("R9 no pulse", p_i, 0);
        chk("R9 count restarted", c_i, 0);

        // R10 force; R3 set beats clear; R11 flag positions
        step(3'b000, 3'b111, 3'b000, 3'b000, 1'b1, 6'b000101);
        step(3'b000, 3'b111, 3'b001, 3'b000, 1'b0, 6'd0);
        chk("R4 flag cleared", flags[0], 0);
        step(3'b000, 3'b111, 3'b010, 3'b011, 1'b0, 6'd0);
        chk("R10 forced pulses", {p_b, p_a, p_i}, 3'b011);
        chk("R3 R11 set beats clear flags", flags, 8'h05);
        step(3'b000, 3'b111, 3'b000, 3'b000, 1'b0, 6'd0);
        chk("R3 pulse one clock wide", {p_b, p_a, p_i}, 0);
        step(3'b100, 3'b111, 3'b000, 3'b000, 1'b1, 6'b010101);
        chk("R8 R2 trigger B fires on write cycle event", p_b, 1);
        chk("R11 flag word", flags, 8'h0D);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule